// File: doc/BRIEF.md
# Two-Wire Register and Strategy-RAM Loader

This block is a target-only two-wire serial (I2C) port that gives a host controller write and read access to a control register file, and lets it stream large tables into a set of strategy RAMs. It watches SCL and SDA through a synchroniser running on the system clock and pulls SDA low through an open-drain enable. It never holds SCL low to stretch the clock and never acts as a bus master. The bus may run at up to 400 kbit/s.

After its device address, the host sends one byte that selects an internal location (the pointer). Later data bytes go to ordinary registers, with the pointer stepping by one after each byte. When the pointer names one of the RAM slots, the bytes go to that RAM, and a private location counter steps by one while the pointer stays put. One register address turns a written byte into a one-cycle soft-reset pulse for the surrounding logic. Reads return the register the pointer names, and they keep returning it until the host stops acknowledging.

All internal ports are single-cycle strobes with no ready signal. A two-wire target without clock stretching cannot pause the bus, so the sinks must accept every strobe in the cycle it appears. The read port is a combinational lookup: `rd_data` must be valid for the current `rd_addr` at every clock.

Top module: `i2c_rf_slave`

## Requirements
- R1: The target answers only to the 7-bit address 110111x, where x is `addr_sel`: write/read bytes DCh/DDh when `addr_sel`=0 and DEh/DFh when 1. Any other address byte gets no acknowledge, and no strobe follows for the rest of that transfer.
- R2: The first byte after a matched write address loads the pointer. It is acknowledged and causes no write strobe.
- R3: Each later data byte to a register pointer gives exactly one `reg_wr_valid` cycle carrying the pointer and the byte. The pointer then steps by one and wraps from FFh to 00h.
- R4: When the pointer equals `RAM_BASE`+k (F0h, F1h by default), each data byte gives one `ram_wr_valid` cycle with `ram_wr_sel`=k and `ram_wr_addr` taken from that RAM's counter. The counter then steps by one and the pointer does not change. Loading the pointer with that RAM slot again resets its counter to 0.
- R5: A data byte with bit 0 set, written while the pointer equals `SRST_ADDR` (FEh), gives one `soft_rst` cycle and no register write.
- R6: After a matched read address, the target shifts out the byte at `rd_addr`, MSB first, and pulses `rd_strobe` once per byte it fetches. Every byte that follows a host acknowledge returns the same register, because reads leave the pointer unchanged.
- R7: A host NACK after a read byte ends the read. The target then leaves SDA released until the next start condition.
- R8: `sda_oe` changes only while SCL is low. Every byte the target accepts is acknowledged by driving SDA low for the ninth clock.
- R9: After reset and after a stop condition the target is idle: SDA is released, no strobes fire, and bytes clocked without a new start get no acknowledge and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that sets the LSB of the device address |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_wr_valid | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | 8 | Register write data |
| rd_addr | output | 8 | Register read address (current pointer) |
| rd_data | input | 8 | Register read data for `rd_addr` |
| rd_strobe | output | 1 | Pulses when a read byte has been fetched |
| ram_wr_valid | output | 1 | One-cycle RAM write strobe |
| ram_wr_sel | output | RAM_SW | RAM being written |
| ram_wr_addr | output | RAM_AW | Location within that RAM |
| ram_wr_data | output | 8 | RAM write data |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
A write and a read can meet within one transfer when a data byte is acknowledged and a repeated start follows with no stop between them. The read's fetch then depends on the pointer step made by that write. The bench provokes this by writing one byte to register 40h, issuing a repeated start with the read address, and reading. It judges the result by requiring exactly one write strobe at 40h and read data that matches register 41h, not 40h.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } link_st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_PTR,
    PH_DATA
  } phase_e;

  typedef struct packed {
    logic       valid;
    logic       is_ptr;
    logic [7:0] data;
  } rx_evt_t;

endpackage

// File: rtl/i2c_rf_bus_sync.sv
module i2c_rf_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rf_link.sv
module i2c_rf_link
  import i2c_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_addr,
  input  logic [7:0] tx_byte,
  output logic       sda_oe,
  output rx_evt_t    evt,
  output logic       tx_load
);

  link_st_e   st;
  phase_e     ph;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic       got, rw, mnack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= PH_DEV;
      cnt     <= '0;
      sh      <= '0;
      got     <= 1'b0;
      rw      <= 1'b0;
      mnack   <= 1'b0;
      sda_oe  <= 1'b0;
      evt     <= '0;
      tx_load <= 1'b0;
    end else begin
      evt.valid <= 1'b0;
      tx_load   <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        ph     <= PH_DEV;
        cnt    <= '0;
        got    <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) got <= 1'b1;
            end else if (scl_fall && got) begin
              got <= 1'b0;
              cnt <= '0;
              if (ph == PH_DEV) begin
                if (sh[7:1] == dev_addr) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  st     <= ST_RACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe     <= 1'b1;
                st         <= ST_RACK;
                evt.valid  <= 1'b1;
                evt.is_ptr <= (ph == PH_PTR);
                evt.data   <= sh;
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (ph == PH_DEV && rw) begin
                st      <= ST_TX;
                sh      <= tx_byte;
                sda_oe  <= ~tx_byte[7];
                tx_load <= 1'b1;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                ph     <= (ph == PH_DEV) ? PH_PTR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TACK;
              end else begin
                sda_oe <= ~sh[6];
                sh     <= {sh[6:0], 1'b0};
                cnt    <= cnt + 3'd1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              if (mnack) begin
                st <= ST_IDLE;
              end else begin
                st      <= ST_TX;
                cnt     <= '0;
                sh      <= tx_byte;
                sda_oe  <= ~tx_byte[7];
                tx_load <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_rf_dispatch.sv
module i2c_rf_dispatch
  import i2c_rf_pkg::*;
#(
  parameter int         NUM_RAMS  = 2,
  parameter int         RAM_AW    = 11,
  parameter int         RAM_SW    = 1,
  parameter logic [7:0] RAM_BASE  = 8'hF0,
  parameter logic [7:0] SRST_ADDR = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_evt_t           evt,
  output logic [7:0]        ptr,
  output logic              reg_wr_valid,
  output logic [7:0]        reg_wr_addr,
  output logic [7:0]        reg_wr_data,
  output logic              ram_wr_valid,
  output logic [RAM_SW-1:0] ram_wr_sel,
  output logic [RAM_AW-1:0] ram_wr_addr,
  output logic [7:0]        ram_wr_data,
  output logic              soft_rst
);

  logic [NUM_RAMS-1:0] ram_hit;
  logic [RAM_AW-1:0]   ram_cnt [NUM_RAMS];
  logic [RAM_SW-1:0]   ram_idx;
  logic                ptr_is_ram;
  logic                data_evt;

  assign data_evt = evt.valid & ~evt.is_ptr;

  for (genvar k = 0; k < NUM_RAMS; k++) begin : g_slot
    localparam logic [7:0] SLOT = 8'(RAM_BASE + k);
    assign ram_hit[k] = (ptr == SLOT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ram_cnt[k] <= '0;
      else if (evt.valid && evt.is_ptr && evt.data == SLOT)
        ram_cnt[k] <= '0;
      else if (data_evt && ram_hit[k])
        ram_cnt[k] <= ram_cnt[k] + 1'b1;
    end
  end

  assign ptr_is_ram = |ram_hit;

  always_comb begin
    ram_idx = '0;
    for (int k = 0; k < NUM_RAMS; k++)
      if (ram_hit[k]) ram_idx = RAM_SW'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr          <= '0;
      reg_wr_valid <= 1'b0;
      reg_wr_addr  <= '0;
      reg_wr_data  <= '0;
      ram_wr_valid <= 1'b0;
      ram_wr_sel   <= '0;
      ram_wr_addr  <= '0;
      ram_wr_data  <= '0;
      soft_rst     <= 1'b0;
    end else begin
      reg_wr_valid <= 1'b0;
      ram_wr_valid <= 1'b0;
      soft_rst     <= 1'b0;
      if (evt.valid) begin
        if (evt.is_ptr) begin
          ptr <= evt.data;
        end else if (ptr_is_ram) begin
          ram_wr_valid <= 1'b1;
          ram_wr_sel   <= ram_idx;
          ram_wr_addr  <= ram_cnt[ram_idx];
          ram_wr_data  <= evt.data;
        end else if (ptr == SRST_ADDR) begin
          soft_rst <= evt.data[0];
        end else begin
          reg_wr_valid <= 1'b1;
          reg_wr_addr  <= ptr;
          reg_wr_data  <= evt.data;
          ptr          <= ptr + 8'd1;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_rf_slave.sv
module i2c_rf_slave
  import i2c_rf_pkg::*;
#(
  parameter int         NUM_RAMS    = 2,
  parameter int         RAM_AW      = 11,
  parameter int         RAM_SW      = (NUM_RAMS > 1) ? $clog2(NUM_RAMS) : 1,
  parameter logic [7:0] RAM_BASE    = 8'hF0,
  parameter logic [7:0] SRST_ADDR   = 8'hFE,
  parameter logic [5:0] DEV_HI      = 6'b110111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              reg_wr_valid,
  output logic [7:0]        reg_wr_addr,
  output logic [7:0]        reg_wr_data,
  output logic [7:0]        rd_addr,
  input  logic [7:0]        rd_data,
  output logic              rd_strobe,
  output logic              ram_wr_valid,
  output logic [RAM_SW-1:0] ram_wr_sel,
  output logic [RAM_AW-1:0] ram_wr_addr,
  output logic [7:0]        ram_wr_data,
  output logic              soft_rst
);

  logic    sda_s, scl_rise, scl_fall, start_det, stop_det;
  rx_evt_t evt;

  i2c_rf_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rf_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  ({DEV_HI, addr_sel}),
    .tx_byte   (rd_data),
    .sda_oe    (sda_oe),
    .evt       (evt),
    .tx_load   (rd_strobe)
  );

  i2c_rf_dispatch #(
    .NUM_RAMS  (NUM_RAMS),
    .RAM_AW    (RAM_AW),
    .RAM_SW    (RAM_SW),
    .RAM_BASE  (RAM_BASE),
    .SRST_ADDR (SRST_ADDR)
  ) u_disp (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt          (evt),
    .ptr          (rd_addr),
    .reg_wr_valid (reg_wr_valid),
    .reg_wr_addr  (reg_wr_addr),
    .reg_wr_data  (reg_wr_data),
    .ram_wr_valid (ram_wr_valid),
    .ram_wr_sel   (ram_wr_sel),
    .ram_wr_addr  (ram_wr_addr),
    .ram_wr_data  (ram_wr_data),
    .soft_rst     (soft_rst)
  );

endmodule

// File: rtl/i2c_rf_slave_chk.sv
module i2c_rf_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_wr_valid,
  input logic ram_wr_valid,
  input logic soft_rst,
  input logic rd_strobe
);

  // R3: a register write is only issued while its byte is being acknowledged
  p_write_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> sda_oe);

  // R4: a RAM write is only issued while its byte is being acknowledged
  p_ram_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_valid |-> sda_oe);

  // R5: the soft reset lasts a single cycle
  p_soft_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  // R8: the SDA driver moves only while SCL is low
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R9: internal strobes never coincide
  p_strobes_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_valid, ram_wr_valid, soft_rst, rd_strobe}));

endmodule

bind i2c_rf_slave i2c_rf_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_i        (scl_i),
  .sda_oe       (sda_oe),
  .reg_wr_valid (reg_wr_valid),
  .ram_wr_valid (ram_wr_valid),
  .soft_rst     (soft_rst),
  .rd_strobe    (rd_strobe)
);

// File: tb/i2c_rf_slave_tb.sv
module i2c_rf_slave_tb;

  localparam int Q = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, addr_sel, scl_m, sda_m;
  logic        sda_oe, sda_bus;
  logic        reg_wr_valid, ram_wr_valid, soft_rst, rd_strobe;
  logic [7:0]  reg_wr_addr, reg_wr_data, rd_addr, rd_data, ram_wr_data;
  logic [0:0]  ram_wr_sel;
  logic [10:0] ram_wr_addr;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = rd_addr ^ 8'h5A;

  i2c_rf_slave u_dut (
    .clk (clk), .rst_n (rst_n), .addr_sel (addr_sel),
    .scl_i (scl_m), .sda_i (sda_bus), .sda_oe (sda_oe),
    .reg_wr_valid (reg_wr_valid), .reg_wr_addr (reg_wr_addr), .reg_wr_data (reg_wr_data),
    .rd_addr (rd_addr), .rd_data (rd_data), .rd_strobe (rd_strobe),
    .ram_wr_valid (ram_wr_valid), .ram_wr_sel (ram_wr_sel), .ram_wr_addr (ram_wr_addr),
    .ram_wr_data (ram_wr_data), .soft_rst (soft_rst)
  );

  int n_vec = 0, n_bad = 0;
  int n_reg = 0, n_ram = 0, n_srst = 0, n_rds = 0, oe_bad = 0;
  logic [7:0]  lg_ra [64];
  logic [7:0]  lg_rd [64];
  logic [0:0]  lg_ms [64];
  logic [10:0] lg_ma [64];
  logic [7:0]  lg_md [64];
  logic        oe_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr_valid && n_reg < 64) begin
        lg_ra[n_reg] = reg_wr_addr; lg_rd[n_reg] = reg_wr_data; n_reg++;
      end
      if (ram_wr_valid && n_ram < 64) begin
        lg_ms[n_ram] = ram_wr_sel; lg_ma[n_ram] = ram_wr_addr; lg_md[n_ram] = ram_wr_data; n_ram++;
      end
      if (soft_rst) n_srst++;
      if (rd_strobe) n_rds++;
      if (sda_oe !== oe_prev && scl_m) oe_bad++;
    end
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    n_reg = 0; n_ram = 0; n_srst = 0; n_rds = 0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wclk(Q);
    scl_m = 1'b1; wclk(2*Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(Q);
    b = sda_bus; wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic nak);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(nak);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~mack);
  endtask

  task automatic t_reset();
    chk("R9 sda_oe after reset", sda_oe, 1'b0);
    chk("R9 no strobes after reset", n_reg + n_ram + n_srst + n_rds, 0);
  endtask

  task automatic t_incr_write();
    logic n0, n1, n2, n3, n4;
    clear_logs();
    bus_start(); wbyte(8'hDC, n0); wbyte(8'h10, n1);
    chk("R2 ptr byte no strobe", n_reg, 0);
    wbyte(8'hA1, n2); wbyte(8'hB2, n3); wbyte(8'hC3, n4); bus_stop();
    chk("R1 own address acked", n0, 1'b0);
    chk("R8 data bytes acked", {n1, n2, n3, n4}, 4'b0);
    chk("R3 write count", n_reg, 3);
    chk("R3 addrs n..n+2", {lg_ra[0], lg_ra[1], lg_ra[2]}, 24'h101112);
    chk("R3 data", {lg_rd[0], lg_rd[1], lg_rd[2]}, 24'hA1B2C3);
    clear_logs();
    bus_start(); wbyte(8'hDC, n0); wbyte(8'hFF, n1); wbyte(8'h11, n2); wbyte(8'h22, n3); bus_stop();
    chk("R3 pointer wrap", {n_reg[7:0], lg_ra[0], lg_ra[1]}, 24'h02FF00);
  endtask

  task automatic t_ram_stream();
    logic n;
    clear_logs();
    bus_start(); wbyte(8'hDC, n); wbyte(8'hF1, n);
    for (int i = 0; i < 4; i++) wbyte(8'h30 + 8'(i), n);
    bus_stop();
    chk("R4 ram write count", n_ram, 4);
    chk("R4 no reg writes", n_reg, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 ram sel", lg_ms[i], 1'b1);
      chk("R4 ram addr step", lg_ma[i], 11'(i));
      chk("R4 ram data", lg_md[i], 8'h30 + 8'(i));
    end
    clear_logs();
    bus_start(); wbyte(8'hDC, n); wbyte(8'hF1, n); wbyte(8'h77, n); bus_stop();
    chk("R4 counter reset on reselect", {lg_ms[0], lg_ma[0]}, {1'b1, 11'd0});
    clear_logs();
    bus_start(); wbyte(8'hDC, n); wbyte(8'hF0, n); wbyte(8'h01, n); wbyte(8'h02, n); bus_stop();
    chk("R4 ram0 stream", {lg_ms[1], lg_ma[1], lg_md[1]}, {1'b0, 11'd1, 8'h02});
  endtask

  task automatic t_soft_reset();
    logic n;
    clear_logs();
    bus_start(); wbyte(8'hDC, n); wbyte(8'hFE, n); wbyte(8'h01, n); bus_stop();
    chk("R5 soft reset pulses", n_srst, 1);
    chk("R5 no reg write", n_reg, 0);
  endtask

  task automatic t_read();
    logic n;
    logic [7:0] v0, v1, v2, vx;
    clear_logs();
    bus_start(); wbyte(8'hDC, n); wbyte(8'h33, n);
    bus_rstart(); wbyte(8'hDD, n);
    chk("R1 read address acked", n, 1'b0);
    rbyte(1'b1, v0); rbyte(1'b1, v1); rbyte(1'b0, v2);
    chk("R6 first read", v0, 8'h33 ^ 8'h5A);
    chk("R6 repeat same reg", {v1, v2}, {2{8'h33 ^ 8'h5A}});
    chk("R6 pointer unchanged", rd_addr, 8'h33);
    chk("R6 fetch strobes", n_rds, 3);
    rbyte(1'b0, vx);
    chk("R7 released after NACK", vx, 8'hFF);
    chk("R7 no fetch after NACK", n_rds, 3);
    bus_stop();
  endtask

  task automatic t_other_address();
    logic n0, n1;
    clear_logs();
    bus_start(); wbyte(8'hDE, n0); wbyte(8'h10, n1); wbyte(8'h99, n1); bus_stop();
    chk("R1 foreign address not acked", n0, 1'b1);
    chk("R1 no strobes for foreign", n_reg + n_ram + n_srst, 0);
    addr_sel = 1'b1;
    bus_start(); wbyte(8'hDE, n0); wbyte(8'h50, n1); wbyte(8'h66, n1); bus_stop();
    chk("R1 strap moves address", {n0, n_reg[7:0], lg_ra[0]}, {1'b0, 8'd1, 8'h50});
    bus_start(); wbyte(8'hDC, n0); bus_stop();
    chk("R1 old address refused", n0, 1'b1);
    addr_sel = 1'b0;
  endtask

  task automatic t_after_stop();
    logic n0, n1;
    clear_logs();
    bus_start(); wbyte(8'hDC, n0); wbyte(8'h20, n0); bus_stop();
    wbyte(8'h44, n0); wbyte(8'h55, n1);
    chk("R9 no ack without start", {n0, n1}, 2'b11);
    chk("R9 no write without start", n_reg, 0);
  endtask

  task automatic t_write_then_read();
    logic n;
    logic [7:0] v;
    clear_logs();
    bus_start(); wbyte(8'hDC, n); wbyte(8'h40, n); wbyte(8'h77, n);
    bus_rstart(); wbyte(8'hDD, n); rbyte(1'b0, v); bus_stop();
    chk("R3 single write before rstart", {n_reg[7:0], lg_ra[0]}, {8'd1, 8'h40});
    chk("R6 read sees stepped pointer", v, 8'h41 ^ 8'h5A);
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; addr_sel = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    wclk(10);
    rst_n = 1'b1;
    wclk(10);
    t_reset();
    t_incr_write();
    t_ram_stream();
    t_soft_reset();
    t_read();
    t_other_address();
    t_after_stop();
    t_write_then_read();
    chk("R8 oe moved only with SCL low", oe_bad, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule